// File: doc/BRIEF.md
# Interrupt Enable and Acceptance Control

This block keeps the processor's interrupt-enable state and decides, cycle by cycle, whether a pending external interrupt request is taken. The request line is asynchronous to the core clock. It is first brought through a flip-flop synchronizer and then checked against the enable state, the bus-hold condition and the instruction sequencing strobes. An accepted request is announced to the fetch sequencer as a one-clock pulse. The sequencer then runs an interrupt acknowledge cycle in place of the next normal opcode fetch.

The instruction decoder sends a pulse to set the enable state and a pulse to clear it. The fetch sequencer sends the end-of-instruction strobe, a level that marks the halted condition, and a strobe for the first state of every opcode fetch. The enable state clears itself on the first fetch state that follows an accepted request, so a second interrupt cannot be accepted in between. When the request is accepted while the processor is halted, a wake pulse also tells the sequencer to leave the halted condition.

Top module: `intr_ctl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the enable output `inte` is 0 after that edge and `int_accept` and `halt_wake` stay 0 until a request has passed through the synchronizer.
- R2: An `ei_pulse` sampled at a rising edge sets `inte` to 1 after that edge, unless a clear of higher priority occurs at the same edge.
- R3: A `di_pulse` sampled at a rising edge clears `inte` to 0 after that edge, even when `ei_pulse` is high at the same edge.
- R4: `int_accept` is asserted only in a clock where `instr_end` or `halted` is high, combinationally in that same clock.
- R5: `int_accept` stays 0 while `hold_active` is high or while `inte` is 0, whatever the request line does.
- R6: After an accept, the first clock with `fetch_t1` high (the accept clock included) clears `inte` at its closing edge.
- R7: An accept in a clock where `halted` is high also raises `halt_wake` in that clock. `halt_wake` is never high without `halted`.
- R8: When an `ei_pulse` comes in the same clock as the auto-clear of R6, the auto-clear wins and `inte` is 0 afterwards.
- R9: The request input is seen by the acceptance logic only after `SYNC_STAGES` (default 2) rising edges. A request that becomes high before edge k can cause an accept no earlier than the clock that follows edge k+1.
- R10: `int_accept` is a single-clock pulse. Between an accept and the following auto-clear, no further accept occurs, even when `instr_end` or `halted` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| int_req_async | input | 1 | External interrupt request, asynchronous |
| ei_pulse | input | 1 | Decoder strobe: set interrupt enable |
| di_pulse | input | 1 | Decoder strobe: clear interrupt enable |
| instr_end | input | 1 | Strobe: current instruction completes this clock |
| halted | input | 1 | Level: processor is in the halted condition |
| hold_active | input | 1 | Level: buses are granted to another master |
| fetch_t1 | input | 1 | Strobe: first state of an opcode fetch cycle |
| inte | output | 1 | Current interrupt-enable state |
| int_accept | output | 1 | One-clock pulse: run an acknowledge cycle instead of the next fetch |
| halt_wake | output | 1 | One-clock pulse: an accept taken while halted; leave the halted state |

## Verification
The assertions assume that the sequencer drives `fetch_t1` for at least one clock after every accept before it raises `instr_end` again, and that `rst` starts high at time zero. They make no assumption about how the request line lines up with the clock. The stimulus drives all inputs half a cycle away from the sampling edge. It always follows an accept with a fetch strobe, and it exercises the request in every state: steady, toggling, and changing in the same clock as the strobes.

// File: rtl/intr_pkg.sv
package intr_pkg;

    localparam int unsigned DEFAULT_SYNC_STAGES = 2;

    typedef struct packed {
        logic en_req;
        logic dis_req;
        logic boundary;
        logic halted;
        logic hold;
        logic fetch_t1;
    } intr_strobe_t;

    typedef enum logic [1:0] {
        IE_KEEP    = 2'd0,
        IE_SET     = 2'd1,
        IE_CLR_SW  = 2'd2,
        IE_CLR_ACK = 2'd3
    } ie_action_t;

    // Priority: acknowledge clear, then software clear, then software set.
    function automatic ie_action_t ie_decide(input intr_strobe_t s,
                                             input logic ack_clear);
        ie_action_t a;
        if (ack_clear)      a = IE_CLR_ACK;
        else if (s.dis_req) a = IE_CLR_SW;
        else if (s.en_req)  a = IE_SET;
        else                a = IE_KEEP;
        return a;
    endfunction

    function automatic logic ie_apply(input ie_action_t a, input logic cur);
        logic n;
        case (a)
            IE_SET:     n = 1'b1;
            IE_CLR_SW:  n = 1'b0;
            IE_CLR_ACK: n = 1'b0;
            default:    n = cur;
        endcase
        return n;
    endfunction

    function automatic logic in_window(input intr_strobe_t s);
        return s.boundary | s.halted;
    endfunction

endpackage

// File: rtl/intr_sync.sv
module intr_sync #(
    parameter int unsigned STAGES = intr_pkg::DEFAULT_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[LAST-1:0], d};
            end
        end
    endgenerate

    assign q = chain[LAST];
endmodule

// File: rtl/intr_accept.sv
module intr_accept
    import intr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         req_sync,
    input  logic         inte,
    input  intr_strobe_t strb,
    output logic         accept,
    output logic         wake,
    output logic         ack_pending,
    output logic         ack_clear
);
    logic pend_q;
    logic qualified;

    always_comb begin
        qualified = req_sync & inte & ~strb.hold & ~pend_q;
        accept    = qualified & in_window(strb);
        wake      = accept & strb.halted;
        ack_clear = strb.fetch_t1 & (pend_q | accept);
    end

    always_ff @(posedge clk) begin
        if (rst)               pend_q <= 1'b0;
        else if (strb.fetch_t1) pend_q <= 1'b0;
        else if (accept)       pend_q <= 1'b1;
    end

    assign ack_pending = pend_q;
endmodule

// File: rtl/intr_enable.sv
module intr_enable
    import intr_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  intr_strobe_t strb,
    input  logic         ack_clear,
    output logic         inte
);
    logic       ie_q;
    ie_action_t act;

    always_comb act = ie_decide(strb, ack_clear);

    always_ff @(posedge clk) begin
        if (rst) ie_q <= 1'b0;
        else     ie_q <= ie_apply(act, ie_q);
    end

    assign inte = ie_q;
endmodule

// File: rtl/intr_ctl.sv
module intr_ctl
    import intr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = DEFAULT_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic int_req_async,
    input  logic ei_pulse,
    input  logic di_pulse,
    input  logic instr_end,
    input  logic halted,
    input  logic hold_active,
    input  logic fetch_t1,
    output logic inte,
    output logic int_accept,
    output logic halt_wake
);
    intr_strobe_t strb;
    logic         req_sync;
    logic         ack_pending;
    logic         ack_clear;
    logic         ie_state;

    always_comb begin
        strb.en_req   = ei_pulse;
        strb.dis_req  = di_pulse;
        strb.boundary = instr_end;
        strb.halted   = halted;
        strb.hold     = hold_active;
        strb.fetch_t1 = fetch_t1;
    end

    intr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (int_req_async),
        .q   (req_sync)
    );

    intr_accept u_acc (
        .clk         (clk),
        .rst         (rst),
        .req_sync    (req_sync),
        .inte        (ie_state),
        .strb        (strb),
        .accept      (int_accept),
        .wake        (halt_wake),
        .ack_pending (ack_pending),
        .ack_clear   (ack_clear)
    );

    intr_enable u_ie (
        .clk       (clk),
        .rst       (rst),
        .strb      (strb),
        .ack_clear (ack_clear),
        .inte      (ie_state)
    );

    assign inte = ie_state;
endmodule

// File: rtl/intr_ctl_chk.sv
module intr_ctl_chk (
    input logic clk,
    input logic rst,
    input logic ei_pulse,
    input logic di_pulse,
    input logic instr_end,
    input logic halted,
    input logic hold_active,
    input logic fetch_t1,
    input logic inte,
    input logic int_accept,
    input logic halt_wake,
    input logic ack_pending
);
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> !inte);

    p_enable_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (ei_pulse && !di_pulse && !(fetch_t1 && (ack_pending || int_accept))) |=> inte);

    p_disable_clears_r3: assert property (@(posedge clk) disable iff (rst)
        di_pulse |=> !inte);

    p_accept_window_r4: assert property (@(posedge clk) disable iff (rst)
        int_accept |-> (instr_end || halted));

    p_accept_blocked_r5: assert property (@(posedge clk) disable iff (rst)
        int_accept |-> (inte && !hold_active));

    p_autoclear_r6: assert property (@(posedge clk) disable iff (rst)
        (fetch_t1 && (ack_pending || int_accept)) |=> !inte);

    p_wake_halted_r7: assert property (@(posedge clk) disable iff (rst)
        halt_wake |-> halted);

    p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        int_accept |=> !int_accept);
endmodule

bind intr_ctl intr_ctl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ei_pulse    (ei_pulse),
    .di_pulse    (di_pulse),
    .instr_end   (instr_end),
    .halted      (halted),
    .hold_active (hold_active),
    .fetch_t1    (fetch_t1),
    .inte        (inte),
    .int_accept  (int_accept),
    .halt_wake   (halt_wake),
    .ack_pending (ack_pending)
);

// File: tb/sim_intr_ctl.sv
module sim_intr_ctl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic irq = 1'b0, ei = 1'b0, di = 1'b0, iend = 1'b0;
    logic hlt = 1'b0, hold = 1'b0, ft1 = 1'b0;
    logic inte, acc, wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    string tag = "R1";

    bit m_inte, m_pend;
    bit m_pipe[$];

    always #4 clk = ~clk;

    intr_ctl u0 (
        .clk(clk), .rst(rst), .int_req_async(irq), .ei_pulse(ei), .di_pulse(di),
        .instr_end(iend), .halted(hlt), .hold_active(hold), .fetch_t1(ft1),
        .inte(inte), .int_accept(acc), .halt_wake(wake)
    );

    task automatic chk(input string what, input logic act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_inte = 0; m_pend = 0;
        m_pipe.delete();
        m_pipe.push_back(1'b0);
        m_pipe.push_back(1'b0);
    endtask

    // Drive one clock of stimulus, compare outputs, advance the model.
    task automatic step(input bit e, input bit d, input bit b, input bit h,
                        input bit hd, input bit f, input bit r);
        bit x_acc, x_wake, x_clr;
        ei = e; di = d; iend = b; hlt = h; hold = hd; ft1 = f; irq = r;
        #1;
        x_acc  = !rst && m_pipe[0] && m_inte && !hd && !m_pend && (b || h);
        x_wake = x_acc && h;
        chk("inte", inte, m_inte);
        chk("int_accept", acc, x_acc);
        chk("halt_wake", wake, x_wake);
        @(posedge clk);
        if (rst) begin
            model_reset();
        end else begin
            void'(m_pipe.pop_front());
            m_pipe.push_back(r);
            x_clr = f && (m_pend || x_acc);
            if (x_clr)  m_inte = 0;
            else if (d) m_inte = 0;
            else if (e) m_inte = 1;
            if (f)          m_pend = 0;
            else if (x_acc) m_pend = 1;
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input bit r);
        for (int i = 0; i < n; i++) step(0,0,0,0,0,0,r);
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        step(1,0,1,0,0,0,1);
        step(0,0,1,1,0,0,1);
        rst = 1'b0;
        idle(3, 0);

        // R2 / R3: set, clear, clear wins over set
        tag = "R2"; step(1,0,0,0,0,0,0); idle(2,0);
        tag = "R3"; step(0,1,0,0,0,0,0); idle(1,0);
        step(1,1,0,0,0,0,0); idle(1,0);

        // R4: request steady, no boundary, then boundary
        tag = "R4"; step(1,0,0,0,0,0,0); idle(5,1);
        step(0,0,1,0,0,0,1);
        // R10: boundary held, no second accept
        tag = "R10"; step(0,0,1,0,0,0,1); step(0,0,1,0,0,0,1);
        // R6 + R8: fetch T1 clears, enable in same clock lost
        tag = "R8"; step(1,0,0,0,0,1,1); step(0,0,1,0,0,0,1);
        tag = "R6"; idle(2,1);

        // R5: hold blocks, disabled blocks
        tag = "R5"; step(1,0,0,0,0,0,1);
        for (int i = 0; i < 4; i++) step(0,0,1,0,1,0,1);
        step(0,1,0,0,0,0,1);
        for (int i = 0; i < 4; i++) step(0,0,1,0,0,0,1);

        // R7: accept while halted, accept and T1 in same clock
        tag = "R7"; step(1,0,0,1,0,0,1);
        step(0,0,0,1,1,0,1);
        step(0,0,0,1,0,0,1);
        step(0,0,0,0,0,1,1);
        tag = "R6"; step(1,0,0,0,0,0,1);
        step(0,0,1,0,0,1,1); idle(2,1);

        // R9: synchronizer latency with boundary held
        tag = "R9"; step(1,0,0,0,0,0,0); idle(3,0);
        for (int i = 0; i < 4; i++) step(0,0,1,0,0,0,1);
        step(0,0,0,0,0,1,0); idle(2,0);
        // R9: short glitch-length request pattern
        step(1,0,0,0,0,0,0);
        for (int i = 0; i < 12; i++) step(0,0,1,0,0,(i%4)==3, i[0]);
        idle(3,0);

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule